// File: doc/BRIEF.md
# Ethernet PHY LED behaviour controller

This block turns the link and status state of an Ethernet PHY into the drive pattern of a small set of status LEDs. Every LED has four condition selectors of its own: steady on, fast blink, slow blink, and an activity mask. Each selector picks one condition from a shared encoding. The conditions are link speeds, power-down, energy-efficient mode, auto-negotiation, analog self-test and cable diagnostics. Two common bytes set the fast and slow blink rates, each between 2 and 16 Hz. The same two bytes also select two chip-wide overrides. The first makes every LED blink. The second lights every LED unless its inverse condition is present.

Blink waveforms come from one free-running prescaler driven by the system clock. A single counter stretches each activity strobe into a visible flash. Configuration bytes are loaded through a plain write port of address, data and write enable. The LED outputs are registered, so a change at the inputs reaches the pins one clock later.

Top module: `led_beh_ctrl`

## Requirements
- R1: While `rst` is high, `led_o` is all zeros. After reset the per-LED bytes take the values steady/fast = 0x70, 0x20, 0x40, 0x40 and slow/mask = 0x03, 0x00, 0x00, 0x20 for LEDs 0 to 3. With the link up at 1000 Mbit/s and no other condition, `led_o` is therefore 4'b1101. With the link down it is 4'b0000.
- R2: A write with `cfg_we` high stores `cfg_wdata` at `cfg_addr` on the clock edge. Addresses 0..N-1 hold the steady/fast byte of LED i. Addresses N..2N-1 hold the slow/mask byte of LED i-N. Address 2N holds the rate byte and address 2N+1 holds the override byte. Other addresses are ignored.
- R3: The 4-bit selector code means the following. 0 is never. 1 to 7 are a speed mask: bit0 = 10, bit1 = 100, bit2 = 1000. The selector is true when `lnk_up` is high and the bit for `lnk_spd` is set, where `lnk_spd` 0 = 10, 1 = 100, 2 = 1000 and 3 = no rate. 8 = power-down, 9 = EEE, 0xA = auto-negotiation, 0xB = self-test, 0xC = cable diagnostics. 0xD to 0xF are never true. The steady selector sits in bits 7:4 of the steady/fast byte.
- R4: The rate byte holds the fast rate code in bits 7:6 and the slow rate code in bits 5:4. Codes 0..3 give 2, 4, 8 and 16 Hz. A blink with code c has a period of (CLK_HZ/32)·2^(4-c) cycles at a 50% duty cycle.
- R5: All LEDs blinking at the same rate are in phase, cycle for cycle.
- R6: Each LED is chosen by priority. The fast selector (bits 3:0 of the steady/fast byte) wins first and gives the fast wave. The slow selector (bits 7:4 of the slow/mask byte) comes next and gives the slow wave. Then comes the steady selector, which gives on. Otherwise the LED is off.
- R7: An activity event inverts an LED's otherwise computed state for exactly STRETCH = CLK_HZ/1000·STRETCH_MS cycles, starting with the output after the strobe's edge. A new event during the stretch restarts it.
- R8: The mask sits in bits 3:0 of the slow/mask byte. Bit0 enables `tx_act`, bit1 enables `rx_act` and bit2 enables `col_act`, and the enabled events combine. Bit3 and any disabled strobe have no effect.
- R9: The 3-bit condition code is 0 never, 1 link up, 2 power-down, 3 EEE, 4 auto-negotiation, 5 self-test, 6 cable diagnostics, 7 test mode. When the blink-override code (override byte bits 2:0) is true, every LED shows the fast wave. This overrides everything else.
- R10: The scan code is in override byte bits 6:4 and the inverse code is in rate byte bits 2:0. When the scan code is true and the inverse code is false, and R9 does not apply, every LED is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| lnk_up | input | 1 | Link is up |
| lnk_spd | input | 2 | Link rate: 0=10, 1=100, 2=1000, 3=none |
| pwr_down | input | 1 | PHY powered down |
| eee_on | input | 1 | Energy-efficient mode active |
| aneg_busy | input | 1 | Auto-negotiation running |
| selftest_busy | input | 1 | Analog self-test running |
| cdiag_busy | input | 1 | Cable diagnostics running |
| test_mode | input | 1 | Test mode running |
| tx_act | input | 1 | Transmit activity strobe |
| rx_act | input | 1 | Receive activity strobe |
| col_act | input | 1 | Collision strobe |
| led_o | output | NUM_LEDS | Registered LED states |

## Verification
The bench sweeps every steady selector code against every link and rate combination and each single status. A decoder that mapped the speed mask bits wrongly, or that let codes 0xD to 0xF light the LED, would show a wrong LED there. It measures the period and high time of every fast and slow rate code. A rate index reversed or off by one would give a period twice or half the expected length. The stretch is checked on both sides of its last cycle, with a retrigger, and against disabled and reserved mask bits. An off-by-one counter or a mask that leaked would flip the LED where it must not. Priority and the two overrides are checked by comparing LEDs cycle for cycle with LEDs that carry a single selector. A wrong order would show up as a mismatch, or as a hang on a blink that never comes.

// File: rtl/led_beh_pkg.sv
package led_beh_pkg;

  // link rate encoding on lnk_spd
  localparam logic [1:0] SPD_10   = 2'd0;
  localparam logic [1:0] SPD_100  = 2'd1;
  localparam logic [1:0] SPD_1000 = 2'd2;

  typedef struct packed {
    logic       link;
    logic [1:0] spd;
    logic       pdown;
    logic       eee;
    logic       aneg;
    logic       selftest;
    logic       cdiag;
    logic       test;
  } phy_stat_t;

  typedef struct packed {
    logic [1:0] fast_code;
    logic [1:0] slow_code;
    logic [2:0] inv_code;
    logic [2:0] scan_code;
    logic [2:0] blink_code;
  } common_cfg_t;

  // reset value of the steady/fast byte for LED idx
  function automatic logic [7:0] hi_reset(input int idx);
    case (idx)
      0:       return 8'h70;
      1:       return 8'h20;
      2, 3:    return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  // reset value of the slow/mask byte for LED idx
  function automatic logic [7:0] lo_reset(input int idx);
    case (idx)
      0:       return 8'h03;
      3:       return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

  // 4-bit LED selector decode
  function automatic logic sel4_hit(input logic [3:0] sel, input phy_stat_t s);
    logic [2:0] rate_oh;
    case (s.spd)
      SPD_10:   rate_oh = 3'b001;
      SPD_100:  rate_oh = 3'b010;
      SPD_1000: rate_oh = 3'b100;
      default:  rate_oh = 3'b000;
    endcase
    if (sel[3] == 1'b0) begin
      return s.link & (|(sel[2:0] & rate_oh));
    end
    case (sel[2:0])
      3'd0:    return s.pdown;
      3'd1:    return s.eee;
      3'd2:    return s.aneg;
      3'd3:    return s.selftest;
      3'd4:    return s.cdiag;
      default: return 1'b0;
    endcase
  endfunction

  // 3-bit common condition decode
  function automatic logic sel3_hit(input logic [2:0] code, input phy_stat_t s);
    case (code)
      3'd1:    return s.link;
      3'd2:    return s.pdown;
      3'd3:    return s.eee;
      3'd4:    return s.aneg;
      3'd5:    return s.selftest;
      3'd6:    return s.cdiag;
      3'd7:    return s.test;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/blink_prescaler.sv
module blink_prescaler #(
  parameter int TICK_CYC = 3906250,
  parameter int PHASE_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  output logic               tick_o,
  output logic [PHASE_W-1:0] phase_o
);
  localparam int CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

  logic [CW-1:0]      cnt_q;
  logic [PHASE_W-1:0] phase_q;

  assign tick_o  = (cnt_q == LAST);
  assign phase_o = phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (tick_o) begin
      cnt_q   <= '0;
      phase_q <= phase_q + 1'b1;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
  import led_beh_pkg::*;
#(
  parameter int NUM_LEDS = 4,
  parameter int ADDR_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [7:0]               wdata,
  output logic [NUM_LEDS-1:0][7:0] hi_o,
  output logic [NUM_LEDS-1:0][7:0] lo_o,
  output common_cfg_t              common_o
);
  localparam logic [ADDR_W-1:0] ADDR_RATE = ADDR_W'(2 * NUM_LEDS);
  localparam logic [ADDR_W-1:0] ADDR_SCAN = ADDR_W'(2 * NUM_LEDS + 1);

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
    logic [7:0] hi_q;
    logic [7:0] lo_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        hi_q <= hi_reset(i);
        lo_q <= lo_reset(i);
      end else if (we) begin
        if (addr == ADDR_W'(i))            hi_q <= wdata;
        if (addr == ADDR_W'(NUM_LEDS + i)) lo_q <= wdata;
      end
    end
    assign hi_o[i] = hi_q;
    assign lo_o[i] = lo_q;
  end

  logic [1:0] fast_q, slow_q;
  logic [2:0] inv_q, scan_q, blink_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_q  <= 2'b11;
      slow_q  <= 2'b00;
      inv_q   <= 3'd5;
      scan_q  <= 3'd6;
      blink_q <= 3'd7;
    end else if (we) begin
      if (addr == ADDR_RATE) begin
        fast_q <= wdata[7:6];
        slow_q <= wdata[5:4];
        inv_q  <= wdata[2:0];
      end
      if (addr == ADDR_SCAN) begin
        scan_q  <= wdata[6:4];
        blink_q <= wdata[2:0];
      end
    end
  end

  assign common_o = '{fast_code: fast_q, slow_code: slow_q, inv_code: inv_q,
                      scan_code: scan_q, blink_code: blink_q};
endmodule

// File: rtl/led_lane.sv
module led_lane
  import led_beh_pkg::*;
#(
  parameter int STRETCH_CYC = 3750000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic [7:0] hi_cfg,
  input  logic [7:0] lo_cfg,
  input  phy_stat_t st,
  input  logic [2:0] act,
  input  logic      fast_wave,
  input  logic      slow_wave,
  input  logic      force_blink,
  input  logic      force_on,
  output logic      led_o
);
  localparam int SW = $clog2(STRETCH_CYC) + 1;
  localparam logic [SW-1:0] RELOAD = SW'(STRETCH_CYC - 1);

  logic [SW-1:0] stretch_q;
  logic          event_now;
  logic          stretching;
  logic          base;
  logic          nxt;
  logic          led_q;

  // mask bit 3 is reserved: it meets a constant zero
  assign event_now  = |(lo_cfg[3:0] & {1'b0, act});
  assign stretching = event_now | (stretch_q != '0);

  always_ff @(posedge clk) begin
    if (rst)                    stretch_q <= '0;
    else if (event_now)         stretch_q <= RELOAD;
    else if (stretch_q != '0)   stretch_q <= stretch_q - 1'b1;
  end

  always_comb begin
    if (sel4_hit(hi_cfg[3:0], st))      base = fast_wave;
    else if (sel4_hit(lo_cfg[7:4], st)) base = slow_wave;
    else                                base = sel4_hit(hi_cfg[7:4], st);

    if (force_blink)     nxt = fast_wave;
    else if (force_on)   nxt = 1'b1;
    else                 nxt = base ^ stretching;
  end

  always_ff @(posedge clk) begin
    if (rst) led_q <= 1'b0;
    else     led_q <= nxt;
  end

  assign led_o = led_q;
endmodule

// File: rtl/led_beh_ctrl.sv
module led_beh_ctrl
  import led_beh_pkg::*;
#(
  parameter int NUM_LEDS   = 4,
  parameter int CLK_HZ     = 125000000,
  parameter int STRETCH_MS = 30,
  localparam int ADDR_W    = $clog2(2 * NUM_LEDS + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [7:0]          cfg_wdata,
  input  logic                lnk_up,
  input  logic [1:0]          lnk_spd,
  input  logic                pwr_down,
  input  logic                eee_on,
  input  logic                aneg_busy,
  input  logic                selftest_busy,
  input  logic                cdiag_busy,
  input  logic                test_mode,
  input  logic                tx_act,
  input  logic                rx_act,
  input  logic                col_act,
  output logic [NUM_LEDS-1:0] led_o
);
  localparam int TICK_CYC    = (CLK_HZ / 32 > 0) ? CLK_HZ / 32 : 1;
  localparam int STRETCH_RAW = (CLK_HZ / 1000) * STRETCH_MS;
  localparam int STRETCH_CYC = (STRETCH_RAW > 0) ? STRETCH_RAW : 1;
  localparam int PHASE_W     = 4;

  phy_stat_t                st;
  common_cfg_t              cmn;
  logic [NUM_LEDS-1:0][7:0] hi_cfg;
  logic [NUM_LEDS-1:0][7:0] lo_cfg;
  logic [PHASE_W-1:0]       blink_phase;
  logic                     rate_tick;
  logic                     fast_wave, slow_wave;
  logic                     force_blink, force_on;

  assign st = '{link: lnk_up, spd: lnk_spd, pdown: pwr_down, eee: eee_on,
                aneg: aneg_busy, selftest: selftest_busy, cdiag: cdiag_busy,
                test: test_mode};

  led_cfg_regs #(.NUM_LEDS(NUM_LEDS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .hi_o(hi_cfg), .lo_o(lo_cfg), .common_o(cmn)
  );

  blink_prescaler #(.TICK_CYC(TICK_CYC), .PHASE_W(PHASE_W)) u_pre (
    .clk(clk), .rst(rst), .tick_o(rate_tick), .phase_o(blink_phase)
  );

  // code 3 picks phase bit 0 (one tick per half period = 16 Hz)
  assign fast_wave   = blink_phase[2'd3 - cmn.fast_code];
  assign slow_wave   = blink_phase[2'd3 - cmn.slow_code];
  assign force_blink = sel3_hit(cmn.blink_code, st);
  assign force_on    = sel3_hit(cmn.scan_code, st) & ~sel3_hit(cmn.inv_code, st);

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_lane
    led_lane #(.STRETCH_CYC(STRETCH_CYC)) u_lane (
      .clk(clk), .rst(rst), .hi_cfg(hi_cfg[i]), .lo_cfg(lo_cfg[i]), .st(st),
      .act({col_act, rx_act, tx_act}), .fast_wave(fast_wave), .slow_wave(slow_wave),
      .force_blink(force_blink), .force_on(force_on), .led_o(led_o[i])
    );
  end
endmodule

// File: rtl/led_beh_chk.sv
module led_beh_chk #(
  parameter int NUM_LEDS = 4,
  parameter int ADDR_W   = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_we,
  input logic [ADDR_W-1:0]   cfg_addr,
  input logic [7:0]          cfg_wdata,
  input logic                lnk_up,
  input logic                pwr_down,
  input logic                eee_on,
  input logic                aneg_busy,
  input logic                selftest_busy,
  input logic                cdiag_busy,
  input logic                test_mode,
  input logic [NUM_LEDS-1:0] led_o,
  input logic [1:0]          fast_code,
  input logic [2:0]          inv_code,
  input logic [2:0]          scan_code,
  input logic [2:0]          blink_code,
  input logic [3:0]          blink_phase,
  input logic                rate_tick
);
  logic [7:0] cond_vec;
  logic       blink_hit, scan_hit, inv_hit;

  assign cond_vec  = {test_mode, cdiag_busy, selftest_busy, aneg_busy,
                      eee_on, pwr_down, lnk_up, 1'b0};
  assign blink_hit = cond_vec[blink_code];
  assign scan_hit  = cond_vec[scan_code];
  assign inv_hit   = cond_vec[inv_code];

  AST_RATE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == ADDR_W'(2 * NUM_LEDS)) |=>
      (fast_code == $past(cfg_wdata[7:6]) && inv_code == $past(cfg_wdata[2:0]))); // R2

  AST_SCAN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == ADDR_W'(2 * NUM_LEDS + 1)) |=>
      (scan_code == $past(cfg_wdata[6:4]) && blink_code == $past(cfg_wdata[2:0]))); // R2

  AST_PHASE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && blink_phase != $past(blink_phase)) |-> $past(rate_tick)); // R4

  AST_BLINK_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(blink_hit)) |->
      (led_o == {NUM_LEDS{led_o[0]}})); // R9

  AST_SCAN_ALL_ON: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(scan_hit && !inv_hit && !blink_hit)) |->
      (led_o == {NUM_LEDS{1'b1}})); // R10
endmodule

bind led_beh_ctrl led_beh_chk #(.NUM_LEDS(NUM_LEDS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .lnk_up(lnk_up), .pwr_down(pwr_down), .eee_on(eee_on), .aneg_busy(aneg_busy),
  .selftest_busy(selftest_busy), .cdiag_busy(cdiag_busy), .test_mode(test_mode),
  .led_o(led_o), .fast_code(cmn.fast_code), .inv_code(cmn.inv_code),
  .scan_code(cmn.scan_code), .blink_code(cmn.blink_code),
  .blink_phase(blink_phase), .rate_tick(rate_tick)
);

// File: tb/led_beh_ctrl_test.sv
`timescale 1ns/1ps
module led_beh_ctrl_test;
  localparam int NL       = 4;
  localparam int CLK_HZ   = 3200;
  localparam int STR_MS   = 30;
  localparam int TICK     = CLK_HZ / 32;
  localparam int STRETCH  = (CLK_HZ / 1000) * STR_MS;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic lnk_up = 1'b0;
  logic [1:0] lnk_spd = 2'd0;
  logic pwr_down = 1'b0, eee_on = 1'b0, aneg_busy = 1'b0, selftest_busy = 1'b0;
  logic cdiag_busy = 1'b0, test_mode = 1'b0;
  logic tx_act = 1'b0, rx_act = 1'b0, col_act = 1'b0;
  logic [NL-1:0] led_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  led_beh_ctrl #(.NUM_LEDS(NL), .CLK_HZ(CLK_HZ), .STRETCH_MS(STR_MS)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .lnk_up(lnk_up), .lnk_spd(lnk_spd), .pwr_down(pwr_down), .eee_on(eee_on),
    .aneg_busy(aneg_busy), .selftest_busy(selftest_busy), .cdiag_busy(cdiag_busy),
    .test_mode(test_mode), .tx_act(tx_act), .rx_act(rx_act), .col_act(col_act),
    .led_o(led_o)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input int got, input int exp, input string what);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 8'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_stat(input int idx);
    pwr_down = (idx == 1); eee_on = (idx == 2); aneg_busy = (idx == 3);
    selftest_busy = (idx == 4); cdiag_busy = (idx == 5);
  endtask

  function automatic int exp_sel(input int sel, input int link, input int spd, input int st);
    if (sel >= 1 && sel <= 7) return (link != 0 && spd != 3 && ((sel >> spd) & 1) != 0) ? 1 : 0;
    case (sel)
      8:  return (st == 1) ? 1 : 0;
      9:  return (st == 2) ? 1 : 0;
      10: return (st == 3) ? 1 : 0;
      11: return (st == 4) ? 1 : 0;
      12: return (st == 5) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic measure(input int idx, output int per, output int hi);
    per = 0; hi = 0;
    while (led_o[idx] !== 1'b0) @(negedge clk);
    while (led_o[idx] !== 1'b1) @(negedge clk);
    while (led_o[idx] === 1'b1) begin hi++; @(negedge clk); end
    per = hi;
    while (led_o[idx] === 1'b0) begin per++; @(negedge clk); end
  endtask

  task automatic cmp_window(input int a, input int b, input int n, output int mism);
    mism = 0;
    for (int k = 0; k < n; k++) begin
      if (led_o[a] !== led_o[b]) mism++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    cyc(WATCHDOG);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    int per, hi, mism;
    // R1: output held low in reset even with a live link
    lnk_up = 1'b1; lnk_spd = 2'd2;
    cyc(4);
    check(led_o, 0, "R1 output during reset");
    lnk_up = 1'b0;
    rst = 1'b0;
    cyc(2);
    check(led_o, 0, "R1 reset config link down");
    lnk_up = 1'b1; lnk_spd = 2'd2;
    cyc(2);
    check(led_o, 4'b1101, "R1 reset config link 1000");

    // R7/R8: stretch using the reset config (LED0 on, mask tx|rx; LED3 mask none)
    tx_act = 1'b1; @(negedge clk); tx_act = 1'b0;
    check(led_o[0], 0, "R7 flip right after strobe");
    check(led_o[3], 1, "R8 unmasked LED ignores tx");
    cyc(STRETCH - 1);
    check(led_o[0], 0, "R7 last stretch cycle");
    cyc(1);
    check(led_o[0], 1, "R7 stretch ended");
    cyc(3);
    col_act = 1'b1; @(negedge clk); col_act = 1'b0;
    check(led_o[0], 1, "R8 collision disabled in mask");
    // R7 retrigger
    rx_act = 1'b1; @(negedge clk); rx_act = 1'b0;
    cyc(STRETCH - 10);
    rx_act = 1'b1; @(negedge clk); rx_act = 1'b0;
    cyc(15);
    check(led_o[0], 0, "R7 retrigger extends stretch");
    cyc(STRETCH);
    check(led_o[0], 1, "R7 retriggered stretch ends");
    // R8: reserved bit only, then collision only
    wr(NL + 0, 8'h08);
    tx_act = 1'b1; rx_act = 1'b1; col_act = 1'b1; @(negedge clk);
    tx_act = 1'b0; rx_act = 1'b0; col_act = 1'b0;
    check(led_o[0], 1, "R8 reserved mask bit no effect");
    cyc(3);
    check(led_o[0], 1, "R8 reserved mask bit still no effect");
    wr(NL + 0, 8'h04);
    col_act = 1'b1; @(negedge clk); col_act = 1'b0;
    check(led_o[0], 0, "R8 collision enabled flips");
    cyc(STRETCH + 2);

    // R2/R3: clear overrides, sweep steady selector on LED0
    wr(2 * NL + 1, 8'h00);
    wr(2 * NL, 8'hC0);
    wr(NL + 0, 8'h00);
    for (int sel = 0; sel < 16; sel++) begin
      wr(0, sel << 4);
      for (int ln = 0; ln < 2; ln++)
        for (int sp = 0; sp < 4; sp++)
          for (int s = 0; s < 6; s++) begin
            lnk_up = ln[0]; lnk_spd = 2'(sp); set_stat(s);
            cyc(2);
            check(led_o[0], exp_sel(sel, ln, sp, s),
                  $sformatf("R3 sel %0h link %0d spd %0d stat %0d", sel, ln, sp, s));
          end
    end
    set_stat(0);
    // R2: address map of LED3 bytes
    wr(3, 8'h10); wr(NL + 3, 8'h00);
    lnk_up = 1'b1; lnk_spd = 2'd0;
    cyc(2);
    check(led_o[3], 1, "R2 LED3 high byte at its address");
    lnk_spd = 2'd1;
    cyc(2);
    check(led_o[3], 0, "R2 LED3 low byte at its address");

    // R4: rates; LED1 fast on any link, LED2 slow on any link
    lnk_spd = 2'd2;
    wr(0, 8'h07); wr(1, 8'h07); wr(2, 8'h00); wr(NL + 2, 8'h70); wr(NL + 1, 8'h00);
    for (int c = 0; c < 4; c++) begin
      wr(2 * NL, (c << 6) | ((3 - c) << 4));
      cyc(2);
      measure(1, per, hi);
      check(per, TICK << (4 - c), $sformatf("R4 fast period code %0d", c));
      check(hi, (TICK << (4 - c)) / 2, $sformatf("R4 fast duty code %0d", c));
      measure(2, per, hi);
      check(per, TICK << (4 - (3 - c)), $sformatf("R4 slow period code %0d", 3 - c));
      check(hi, (TICK << (4 - (3 - c))) / 2, $sformatf("R4 slow duty code %0d", 3 - c));
    end
    // R5: same rate in phase
    cmp_window(0, 1, 800, mism);
    check(mism, 0, "R5 fast LEDs in phase");

    // R6: priority
    wr(2 * NL, 8'hC0);
    wr(0, 8'h78); wr(NL + 0, 8'h90);
    wr(1, 8'h08); wr(2, 8'h00); wr(NL + 2, 8'h90);
    pwr_down = 1'b1; eee_on = 1'b1;
    cyc(2);
    cmp_window(0, 1, 400, mism);
    check(mism, 0, "R6 fast wins over slow and steady");
    pwr_down = 1'b0;
    cyc(2);
    cmp_window(0, 2, 3200, mism);
    check(mism, 0, "R6 slow wins over steady");
    eee_on = 1'b0;
    cyc(2);
    mism = 0;
    for (int k = 0; k < 300; k++) begin
      if (led_o[0] !== 1'b1) mism++;
      @(negedge clk);
    end
    check(mism, 0, "R6 steady on when no blink");

    // R9/R10: overrides
    for (int i = 0; i < NL; i++) begin
      wr(i, 8'h00); wr(NL + i, 8'h00);
    end
    wr(NL + 0, 8'h01);
    wr(2 * NL, 8'hC5);
    wr(2 * NL + 1, 8'h67);
    cdiag_busy = 1'b1;
    cyc(2);
    check(led_o, 4'hF, "R10 scan lights all");
    selftest_busy = 1'b1;
    cyc(2);
    check(led_o, 4'h0, "R10 inverse cancels scan");
    selftest_busy = 1'b0; test_mode = 1'b1;
    cyc(2);
    tx_act = 1'b1; @(negedge clk); tx_act = 1'b0;
    cmp_window(0, 3, 400, mism);
    check(mism, 0, "R9 blink override uniform despite strobe");
    measure(0, per, hi);
    check(per, TICK << 1, "R9 override blinks at fast rate over scan");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule